// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block sits between the character output of a UART receiver and the write port of the receive FIFO. It is used on a shared multidrop line. A node on that line should keep only the traffic that is addressed to it. Each received character carries a marker that says whether it is an address or ordinary data:

- When parity is enabled, the marker is the parity bit.
- When parity is disabled, the marker is the most significant configured data bit.

The block compares each address character against two programmable station addresses. It writes to the FIFO only the characters that belong to a selected conversation.

An address that matches selects the node. That address character and all data characters after it are written to the FIFO. An address that matches neither register deselects the node, and data characters are then dropped until the next matching address arrives.

A transmit-permit output supports two policies:
- transmit freely;
- transmit only while the node is selected.

When the filter is disabled, every good character passes through and the node is held deselected. A character flagged with a framing or parity error is never written. It never changes the selection, and it produces a one-cycle error strobe instead.

Top module: `mdf_filter`

## Requirements
- R1: Outputs are registered. A character presented with `char_valid_i` high appears on `fifo_we_o`/`fifo_data_o`/`err_o` after the next rising clock edge. With `char_valid_i` low, `fifo_we_o` and `err_o` are 0. After reset the node is deselected, and `fifo_we_o`=0 and `err_o`=0.
- R2: With `en_i`=0, every character without error is written. `fifo_data_o` is the character masked to its configured width, with bits at and above `char_bits_i` cleared.
- R3: With `en_i`=1, an address character whose value equals `addr0_i` or `addr1_i` selects the node, and the address character itself is written.
- R4: While the node is selected, data characters (marker 0) are written. While it is deselected, they are dropped.
- R5: An address character that matches neither register deselects the node and is not written.
- R6: When `par_en_i`=1, the marker is `par_bit_i`, and the compared value is all configured data bits. When `par_en_i`=0, the marker is data bit `char_bits_i`-1, and the compared value is the data bits below it.
- R7: `char_bits_i` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. Unused upper bits of `char_data_i` are treated as zero in both the comparison and the written data.
- R8: A character with `char_err_i`=1 is never written. It pulses `err_o` for one cycle and leaves the selection unchanged.
- R9: `tx_allow_o` is 1 when `en_i`=0 or when `tx_mode_i`=0 (free transmit). When `en_i`=1 and `tx_mode_i`=1, `tx_allow_o` follows the selected state, so it is 0 after reset and after a rejected address.
- R10: A clock edge with `en_i`=0 deselects the node. After the filter is re-enabled, data is dropped until a matching address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Filter enable |
| tx_mode_i | input | 1 | 0: free transmit, 1: transmit only while selected |
| char_valid_i | input | 1 | Received character strobe |
| char_data_i | input | 9 | Received data bits, LSB aligned |
| char_bits_i | input | 4 | Configured data bit count (5..9) |
| par_en_i | input | 1 | Parity present; marker taken from parity bit |
| par_bit_i | input | 1 | Received parity bit |
| char_err_i | input | 1 | Framing or parity error on this character |
| addr0_i | input | 9 | First station address |
| addr1_i | input | 9 | Second station address |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 9 | FIFO write data, masked to width |
| err_o | output | 1 | Errored character strobe |
| tx_allow_o | output | 1 | Transmit permit |

## Verification
The in-RTL properties check the following on every cycle:
- the selection register follows accepted and rejected addresses;
- the selection register clears while the filter is disabled;
- the selection register holds across data and errored characters;
- writes and error strobes never coincide;
- a rejected address blocks transmission in the gated policy.

Some behaviour can only be shown by the bench's directed scenarios, because it depends on the exact data value:
- the choice of marker bit under each parity setting;
- masking at 5-, 8- and 9-bit widths;
- clamping of out-of-range widths;
- the actual written values.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
  localparam int unsigned MAX_W    = 9;
  localparam int unsigned MIN_W    = 5;
  localparam int unsigned BITS_W   = 4;
  localparam int unsigned NUM_ADDR = 2;

  typedef logic [MAX_W-1:0] char_t;

  typedef enum logic {
    TX_FREE        = 1'b0,
    TX_AFTER_MATCH = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/mdf_classify.sv
module mdf_classify
  import mdf_pkg::*;
#(
  parameter int unsigned CW = MAX_W,
  parameter int unsigned MW = MIN_W,
  parameter int unsigned BW = BITS_W,
  parameter int unsigned NA = NUM_ADDR
) (
  input  logic [CW-1:0]         data_i,
  input  logic [BW-1:0]         bits_i,
  input  logic                  par_en_i,
  input  logic                  par_bit_i,
  input  logic [NA-1:0][CW-1:0] addr_i,
  output logic [CW-1:0]         masked_o,
  output logic                  is_addr_o,
  output logic                  hit_o
);
  localparam logic [BW-1:0] W_MIN = BW'(MW);
  localparam logic [BW-1:0] W_MAX = BW'(CW);
  localparam logic [CW-1:0] ONES  = {CW{1'b1}};

  logic [BW-1:0] w;
  logic [BW-1:0] top_idx;
  logic [CW-1:0] char_mask;
  logic [CW-1:0] val_mask;
  logic [CW-1:0] value;
  logic [NA-1:0] eq;

  // out-of-range widths clamp to the nearest legal one
  always_comb begin
    if (bits_i < W_MIN)      w = W_MIN;
    else if (bits_i > W_MAX) w = W_MAX;
    else                     w = bits_i;
  end

  assign top_idx   = w - 1'b1;
  assign char_mask = ONES >> (W_MAX - w);
  assign val_mask  = par_en_i ? char_mask : (char_mask >> 1);
  assign masked_o  = data_i & char_mask;
  assign value     = data_i & val_mask;
  assign is_addr_o = par_en_i ? par_bit_i : data_i[top_idx];

  for (genvar g = 0; g < NA; g++) begin : g_cmp
    assign eq[g] = (value == addr_i[g]);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/mdf_match.sv
module mdf_match (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic step_i,
  input  logic is_addr_i,
  input  logic hit_i,
  output logic matched_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  matched_o <= 1'b0;
    else if (!en_i)               matched_o <= 1'b0;
    else if (step_i && is_addr_i) matched_o <= hit_i;
  end

  // R3
  accept_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && is_addr_i && hit_i) |=> matched_o);
  // R5
  reject_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && is_addr_i && !hit_i) |=> !matched_o);
  // R10
  disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !matched_o);
  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(step_i && is_addr_i)) |=> $stable(matched_o));
endmodule

// File: rtl/mdf_filter.sv
module mdf_filter
  import mdf_pkg::*;
#(
  parameter int unsigned CW = MAX_W,
  parameter int unsigned BW = BITS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tx_mode_i,
  input  logic          char_valid_i,
  input  logic [CW-1:0] char_data_i,
  input  logic [BW-1:0] char_bits_i,
  input  logic          par_en_i,
  input  logic          par_bit_i,
  input  logic          char_err_i,
  input  logic [CW-1:0] addr0_i,
  input  logic [CW-1:0] addr1_i,
  output logic          fifo_we_o,
  output logic [CW-1:0] fifo_data_o,
  output logic          err_o,
  output logic          tx_allow_o
);
  logic [1:0][CW-1:0] addrs;
  logic [CW-1:0]      masked;
  logic               is_addr;
  logic               hit;
  logic               matched;
  logic               step;
  logic               we_d;

  assign addrs = {addr1_i, addr0_i};

  mdf_classify #(.CW(CW), .MW(MIN_W), .BW(BW), .NA(2)) u_cls (
    .data_i   (char_data_i),
    .bits_i   (char_bits_i),
    .par_en_i (par_en_i),
    .par_bit_i(par_bit_i),
    .addr_i   (addrs),
    .masked_o (masked),
    .is_addr_o(is_addr),
    .hit_o    (hit)
  );

  assign step = char_valid_i && !char_err_i;

  mdf_match u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .step_i   (step),
    .is_addr_i(is_addr),
    .hit_i    (hit),
    .matched_o(matched)
  );

  assign we_d = step && (!en_i || (is_addr ? hit : matched));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_we_o   <= 1'b0;
      fifo_data_o <= '0;
      err_o       <= 1'b0;
    end else begin
      fifo_we_o <= we_d;
      err_o     <= char_valid_i && char_err_i;
      if (we_d) fifo_data_o <= masked;
    end
  end

  assign tx_allow_o = !en_i || (tx_mode_e'(tx_mode_i) == TX_FREE) || matched;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_valid_i |=> (!fifo_we_o && !err_o));
  // R2
  bypass_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !en_i) |=> fifo_we_o);
  // R8
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_we_o && err_o));
  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && char_err_i && en_i) |=> $stable(matched));
  // R9
  tx_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tx_mode_i && $past(en_i && step && is_addr && !hit)) |-> !tx_allow_o);
endmodule

// File: tb/mdf_filter_test.sv
`timescale 1ns/1ps
module mdf_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, mode = 1'b0, valid = 1'b0;
  logic [8:0] data = '0;
  logic [3:0] bits = 4'd8;
  logic       pen = 1'b0, pbit = 1'b0, cerr = 1'b0;
  logic [8:0] a0 = '0, a1 = '0;
  logic       we, err, txa;
  logic [8:0] wdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mdf_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tx_mode_i(mode),
    .char_valid_i(valid), .char_data_i(data), .char_bits_i(bits),
    .par_en_i(pen), .par_bit_i(pbit), .char_err_i(cerr),
    .addr0_i(a0), .addr1_i(a1),
    .fifo_we_o(we), .fifo_data_o(wdata), .err_o(err), .tx_allow_o(txa)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one character for one edge, sample at the following negedge
  task automatic send(input logic [8:0] d, input logic pb, input logic e);
    @(negedge clk);
    data = d; pbit = pb; cerr = e; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; cerr = 1'b0;
  endtask

  task automatic expect_char(input string tag, input logic ew, input logic [8:0] ed,
                             input logic ee, input logic et);
    chk({tag, " we"}, {8'd0, we}, {8'd0, ew});
    if (ew) chk({tag, " data"}, wdata, ed);
    chk({tag, " err"}, {8'd0, err}, {8'd0, ee});
    chk({tag, " tx"}, {8'd0, txa}, {8'd0, et});
  endtask

  task automatic t_reset();
    en = 1'b1; mode = 1'b1;
    #1;
    chk("R1 reset we", {8'd0, we}, 9'd0);
    chk("R1 reset err", {8'd0, err}, 9'd0);
    chk("R9 reset tx gated", {8'd0, txa}, 9'd0);
    @(negedge clk);
    chk("R1 idle we", {8'd0, we}, 9'd0);
  endtask

  task automatic t_bypass();
    en = 1'b0; mode = 1'b1; bits = 4'd8; pen = 1'b0;
    send(9'h1FF, 1'b0, 1'b0);
    expect_char("R2 bypass addr", 1'b1, 9'h0FF, 1'b0, 1'b1);
    send(9'h13C, 1'b0, 1'b0);
    expect_char("R2 bypass data", 1'b1, 9'h03C, 1'b0, 1'b1);
  endtask

  task automatic t_match8();
    en = 1'b1; mode = 1'b1; bits = 4'd8; pen = 1'b0; a0 = 9'h025; a1 = 9'h013;
    send(9'h042, 1'b0, 1'b0);
    expect_char("R4 data before select", 1'b0, 9'h0, 1'b0, 1'b0);
    send(9'h0A5, 1'b0, 1'b0);
    expect_char("R3 addr0 match", 1'b1, 9'h0A5, 1'b0, 1'b1);
    send(9'h042, 1'b0, 1'b0);
    expect_char("R4 data selected", 1'b1, 9'h042, 1'b0, 1'b1);
    send(9'h0C0, 1'b0, 1'b0);
    expect_char("R5 reject addr", 1'b0, 9'h0, 1'b0, 1'b0);
    send(9'h011, 1'b0, 1'b0);
    expect_char("R5 data dropped", 1'b0, 9'h0, 1'b0, 1'b0);
    send(9'h093, 1'b0, 1'b0);
    expect_char("R3 addr1 match", 1'b1, 9'h093, 1'b0, 1'b1);
  endtask

  task automatic t_parity9();
    en = 1'b1; mode = 1'b1; bits = 4'd9; pen = 1'b1; a0 = 9'h155;
    send(9'h155, 1'b1, 1'b0);
    expect_char("R6 parity addr", 1'b1, 9'h155, 1'b0, 1'b1);
    send(9'h1FF, 1'b0, 1'b0);
    expect_char("R6 msb is data", 1'b1, 9'h1FF, 1'b0, 1'b1);
    send(9'h0AA, 1'b1, 1'b0);
    expect_char("R6 parity reject", 1'b0, 9'h0, 1'b0, 1'b0);
    pen = 1'b0;
  endtask

  task automatic t_width5();
    en = 1'b1; mode = 1'b1; bits = 4'd5; pen = 1'b0; a1 = 9'h003;
    send(9'h1F3, 1'b0, 1'b0);
    expect_char("R7 w5 addr", 1'b1, 9'h013, 1'b0, 1'b1);
    send(9'h1EA, 1'b0, 1'b0);
    expect_char("R7 w5 data", 1'b1, 9'h00A, 1'b0, 1'b1);
    bits = 4'd2;
    send(9'h017, 1'b0, 1'b0);
    expect_char("R7 clamp low reject", 1'b0, 9'h0, 1'b0, 1'b0);
    bits = 4'd15; pen = 1'b1; a0 = 9'h1C3;
    send(9'h1C3, 1'b1, 1'b0);
    expect_char("R7 clamp high addr", 1'b1, 9'h1C3, 1'b0, 1'b1);
    pen = 1'b0; bits = 4'd8;
  endtask

  task automatic t_error();
    en = 1'b1; mode = 1'b1; bits = 4'd8; pen = 1'b0; a0 = 9'h025;
    send(9'h0A5, 1'b0, 1'b0);
    send(9'h0FF, 1'b0, 1'b1);
    expect_char("R8 err bad addr", 1'b0, 9'h0, 1'b1, 1'b1);
    send(9'h033, 1'b0, 1'b0);
    expect_char("R8 still selected", 1'b1, 9'h033, 1'b0, 1'b1);
    send(9'h0C0, 1'b0, 1'b0);
    send(9'h0A5, 1'b0, 1'b1);
    expect_char("R8 err good addr", 1'b0, 9'h0, 1'b1, 1'b0);
    send(9'h033, 1'b0, 1'b0);
    expect_char("R8 still deselected", 1'b0, 9'h0, 1'b0, 1'b0);
  endtask

  task automatic t_txfree();
    en = 1'b1; mode = 1'b0;
    send(9'h0C0, 1'b0, 1'b0);
    expect_char("R9 free tx", 1'b0, 9'h0, 1'b0, 1'b1);
    mode = 1'b1; #1;
    chk("R9 gated tx", {8'd0, txa}, 9'd0);
  endtask

  task automatic t_reenable();
    en = 1'b1; mode = 1'b1; bits = 4'd8; pen = 1'b0;
    send(9'h0A5, 1'b0, 1'b0);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1; #1;
    chk("R10 tx after reenable", {8'd0, txa}, 9'd0);
    send(9'h044, 1'b0, 1'b0);
    expect_char("R10 data dropped", 1'b0, 9'h0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_match8();
    t_parity9();
    t_width5();
    t_error();
    t_txfree();
    t_reenable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule